// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register front end of a DMA channel that feeds a SCSI controller. It holds four 32-bit word registers selected by the byte address. Word 0 is the channel control and status word, word 1 holds the transfer address, and words 2 and 3 are general storage. The block does not move data and does not translate addresses. It only keeps the channel state that software programs and reads back.

A write to the control word is rewritten before it is stored:

- A set bit 7 raises a one-clock reset strobe toward the attached controller.
- Otherwise a set bit 6 is dropped.
- Otherwise an all-zero write becomes 0x40.
- The top nibble is always forced to the channel version code.

Writing the address word also overwrites the control word with a fixed "address loaded" pattern. An external completion strobe sets control bit 0 and raises the interrupt output. The interrupt stays high until a control write with bit 4 clear removes it.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000, words 1 to 3 read 0, `irq` is 0 and `ctl_reset` is 0.
- R2: The word index is `bus_addr[3:2]`, and `bus_addr[1:0]` are ignored. Words 2 and 3 store and return all 32 written bits. A write to them leaves word 0 unchanged.
- R3: A control write (index 0) stores bits 27:0 of the processed value. Bits 31:28 always read 0xA, whatever was written there.
- R4: A control write with bit 7 set drives `ctl_reset` high for exactly the one cycle after the write edge. The value is then stored with bit 6 as written.
- R5: A control write with bit 7 clear and bit 6 set stores bit 6 as 0. All other bits are kept.
- R6: A control write of exactly 0 stores 0x40, so the word reads 0xA0000040.
- R7: A write to index 1 stores the address in word 1 and sets word 0 to exactly 0x04000000.
- R8: A one-cycle `xfer_done` pulse sets bit 0 of word 0 and raises `irq` one cycle later. `irq` then stays high with no further input.
- R9: A control write with bit 4 clear lowers `irq` one cycle later. A control write with bit 4 set leaves `irq` as it was.
- R10: When `xfer_done` arrives in the same cycle as a control or address write, bit 0 is set on top of the newly stored word. In that case `irq` ends high even if bit 4 of the write was clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| xfer_done | input | 1 | One-cycle transfer completion strobe |
| irq | output | 1 | Held interrupt request |
| ctl_reset | output | 1 | One-clock reset strobe to the attached controller |

## Verification
The bench checks the order of the three write rewrites. A write carrying both bit 7 and bit 6 must keep bit 6; a design that tests bit 6 first would clear it. A write carrying bit 6 on a non-zero value must not be mistaken for the zero case. A design that forgot to force the nibble would return the written top bits, and one that OR-ed the nibble into the address-loaded pattern would read 0xA4000000 instead of 0x04000000. The bench also lands a completion pulse on the same edge as a control write with bit 4 clear and as an address write. A design whose clear wins would drop the interrupt, and one that applied the write after the completion would lose bit 0.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    // Word indices whose position is decoded by software.
    localparam int unsigned CTL_IDX  = 0;
    localparam int unsigned ADDR_IDX = 1;

    // Control word bit positions with behaviour attached.
    localparam int unsigned DONE_BIT   = 0;
    localparam int unsigned IRQKEEP_BIT = 4;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned RESET_BIT  = 7;

    // Value substituted for an all-zero control write.
    localparam logic [31:0] ZERO_SUBST = 32'h0000_0040;

endpackage

// File: rtl/dma_ctl_wr_xform.sv
module dma_ctl_wr_xform
    import dma_ctl_pkg::*;
#(
    parameter int unsigned     DATA_W  = 32,
    parameter logic [3:0]      VERSION = 4'hA
) (
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored,
    output logic              reset_req
);
    localparam int unsigned KEEP_W = DATA_W - 4;

    logic [DATA_W-1:0] proc_d;
    logic              unused_top;

    always_comb begin
        proc_d    = wdata;
        reset_req = 1'b0;
        if (wdata[RESET_BIT]) begin
            reset_req = 1'b1;
        end else if (wdata[TOGGLE_BIT]) begin
            proc_d[TOGGLE_BIT] = 1'b0;
        end else if (wdata == '0) begin
            proc_d = DATA_W'(ZERO_SUBST);
        end
        stored = {VERSION, proc_d[KEEP_W-1:0]};
    end

    assign unused_top = ^proc_d[DATA_W-1:KEEP_W];

endmodule

// File: rtl/dma_ctl_irq_gate.sv
module dma_ctl_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr_req) irq_d = 1'b0;
        if (set_req) irq_d = 1'b1;   // completion outranks a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4,
    parameter logic [3:0]  VERSION  = 4'hA,
    parameter logic [31:0] LOADED   = 32'h0400_0000,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned ADDR_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_done,
    output logic              irq,
    output logic              ctl_reset
);
    localparam logic [DATA_W-1:0] CTL_RST = {VERSION, {(DATA_W-4){1'b0}}};

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            pulse;
    } state_t;

    state_t            state_d, state_q;
    logic [IDX_W-1:0]  idx;
    logic              ctl_hit, addr_hit;
    logic [DATA_W-1:0] xf_value;
    logic              xf_reset;
    logic [DATA_W-1:0] ctl_q;
    logic              unused_lsb;

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign ctl_hit    = bus_wr && (idx == IDX_W'(CTL_IDX));
    assign addr_hit   = bus_wr && (idx == IDX_W'(ADDR_IDX));

    dma_ctl_wr_xform #(
        .DATA_W  (DATA_W),
        .VERSION (VERSION)
    ) u_xform (
        .wdata     (bus_wdata),
        .stored    (xf_value),
        .reset_req (xf_reset)
    );

    dma_ctl_irq_gate u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (xfer_done),
        .clr_req (ctl_hit && !bus_wdata[IRQKEEP_BIT]),
        .irq     (irq)
    );

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (ctl_hit) begin
            state_d.regs[CTL_IDX] = xf_value;
            state_d.pulse         = xf_reset;
        end else if (addr_hit) begin
            state_d.regs[ADDR_IDX] = bus_wdata;
            state_d.regs[CTL_IDX]  = DATA_W'(LOADED);
        end else if (bus_wr) begin
            state_d.regs[idx] = bus_wdata;
        end
        if (xfer_done) state_d.regs[CTL_IDX][DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.regs          <= '0;
            state_q.regs[CTL_IDX] <= CTL_RST;
            state_q.pulse         <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl_q     = state_q.regs[CTL_IDX];
    assign bus_rdata = state_q.regs[idx];
    assign ctl_reset = state_q.pulse;

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
    parameter logic [3:0]  VERSION = 4'hA,
    parameter logic [31:0] LOADED  = 32'h0400_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        xfer_done,
    input logic        irq,
    input logic        ctl_reset,
    input logic [31:0] ctl_q
);
    logic w_ctl, w_addr;
    assign w_ctl  = bus_wr && (bus_addr[3:2] == 2'd0);
    assign w_addr = bus_wr && (bus_addr[3:2] == 2'd1);

    AST_VERSION_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        w_ctl |=> ctl_q[31:28] == VERSION);                                   // R3
    AST_RESET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ctl && bus_wdata[7]) |=> ctl_reset);                               // R4
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_ctl && bus_wdata[7]) |=> !ctl_reset);                             // R4
    AST_BIT6_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ctl && !bus_wdata[7] && bus_wdata[6]) |=> !ctl_q[6]);              // R5
    AST_ZERO_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ctl && bus_wdata == 32'd0 && !xfer_done) |=> ctl_q == {VERSION, 28'h40}); // R6
    AST_LOADED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        w_addr |=> ctl_q[31:1] == LOADED[31:1]);                              // R7
    AST_DONE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> irq && ctl_q[0]);                                       // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ctl && !bus_wdata[4] && !xfer_done) |=> !irq);                     // R9
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(w_ctl && !bus_wdata[4])) |=> irq);                          // R8

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(
    .VERSION (VERSION),
    .LOADED  (LOADED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .xfer_done (xfer_done),
    .irq       (irq),
    .ctl_reset (ctl_reset),
    .ctl_q     (ctl_q)
);

// File: tb/dma_ctl_regs_test.sv
`timescale 1ns/1ps
module dma_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        xfer_done = 1'b0;
    logic        irq;
    logic        ctl_reset;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dma_ctl_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .xfer_done (xfer_done),
        .irq       (irq),
        .ctl_reset (ctl_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Write one word; returns at the next falling edge, after the update.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic done);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; xfer_done = done;
        @(negedge clk);
        bus_wr = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); check("R1 word0", v, 32'hA000_0000);
        rd(4'h4, v); check("R1 word1", v, 32'h0);
        rd(4'h8, v); check("R1 word2", v, 32'h0);
        rd(4'hC, v); check("R1 word3", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 ctl_reset", {31'd0, ctl_reset}, 32'd0);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        wr(4'h8, 32'hDEAD_BEEF, 1'b0);
        wr(4'hF, 32'h1234_5678, 1'b0);   // low address bits ignored
        rd(4'h8, v); check("R2 word2", v, 32'hDEAD_BEEF);
        rd(4'hC, v); check("R2 word3 via offset 3", v, 32'h1234_5678);
        rd(4'h1, v); check("R2 word0 untouched", v, 32'hA000_0000);
    endtask

    task automatic t_version();
        logic [31:0] v;
        wr(4'h0, 32'hF123_4539, 1'b0);
        rd(4'h0, v); check("R3 nibble forced", v, 32'hA123_4539);
        check("R3 no strobe", {31'd0, ctl_reset}, 32'd0);
    endtask

    task automatic t_bit6();
        logic [31:0] v;
        wr(4'h0, 32'h5A00_0054, 1'b0);
        rd(4'h0, v); check("R5 bit6 dropped", v, 32'hAA00_0014);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(4'h0, 32'h0, 1'b0);
        rd(4'h0, v); check("R6 zero substitution", v, 32'hA000_0040);
    endtask

    task automatic t_strobe();
        logic [31:0] v;
        wr(4'h0, 32'h0000_00C0, 1'b0);
        check("R4 strobe high", {31'd0, ctl_reset}, 32'd1);
        rd(4'h0, v); check("R4 bit6 kept", v, 32'hA000_00C0);
        @(negedge clk);
        check("R4 strobe one cycle", {31'd0, ctl_reset}, 32'd0);
    endtask

    task automatic t_loaded();
        logic [31:0] v;
        wr(4'h0, 32'h0000_0123, 1'b0);
        wr(4'h4, 32'h00FF_1000, 1'b0);
        rd(4'h4, v); check("R7 address stored", v, 32'h00FF_1000);
        rd(4'h0, v); check("R7 loaded pattern", v, 32'h0400_0000);
    endtask

    task automatic t_done();
        logic [31:0] v;
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        check("R8 irq raised", {31'd0, irq}, 32'd1);
        rd(4'h0, v); check("R8 done bit", v, 32'h0400_0001);
        repeat (3) @(negedge clk);
        check("R8 irq held", {31'd0, irq}, 32'd1);
        wr(4'h0, 32'h0000_0010, 1'b0);
        check("R9 bit4 set keeps irq", {31'd0, irq}, 32'd1);
        rd(4'h0, v); check("R9 stored", v, 32'hA000_0010);
        wr(4'h0, 32'h0000_0020, 1'b0);
        check("R9 bit4 clear drops irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(4'h0, 32'h0, 1'b1);
        rd(4'h0, v); check("R10 done on control write", v, 32'hA000_0041);
        check("R10 irq set wins", {31'd0, irq}, 32'd1);
        wr(4'h4, 32'h0000_2000, 1'b1);
        rd(4'h0, v); check("R10 done on address write", v, 32'h0400_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_version();
        t_bit6();
        t_zero();
        t_strobe();
        t_loaded();
        t_done();
        t_race();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule